// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Output Updates

This block controls a port of general-purpose pins. Software reaches it through a plain memory-mapped register bus made of an address, a write strobe with write data, and a read strobe with read data. It holds an output latch and a direction mask that together produce each pin's driven value and output enable, and a captured copy of the pin inputs that can be read back.

Three write-only registers let software raise, lower or flip any chosen group of output bits in a single bus write. No read-modify-write sequence is needed, so two agents touching different pins of the port cannot undo each other's changes. Input capture runs through a two-flop synchronizer. A per-pin digital-enable mask forces unused pins to read 0, and a port-enable input freezes the captured inputs while it is low.

The bus is a control path with no flow control. A write is accepted on every clock edge where the write strobe is high. Read data is combinational from the address while the read strobe is high and is 0 otherwise.

Top module: `pio_port`

## Requirements
- R1: After reset the output latch, direction mask and captured inputs are all 0, so `pin_oe` and `pin_out` are 0 on every pin.
- R2: The output latch at byte offset 0x00 is read/write. A write takes effect at the edge on which it is accepted, so a read in the following cycle returns the new value.
- R3: A write to offset 0x04 sets to 1 every output latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x08 clears to 0 every output latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts every output latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C always return 0.
- R7: The direction mask at offset 0x14 is read/write, with 1 meaning output. `pin_oe` equals the mask, and `pin_out` carries the output latch bit only where the mask bit is 1 and is 0 elsewhere.
- R8: Offset 0x10 returns the captured pin inputs. A pin level that is held steady is visible there from the third rising edge after it is applied.
- R9: A captured input bit whose `dig_en` bit is 0 reads 0.
- R10: While `port_en` is low, the captured inputs hold their last value whatever the pins do, and capture resumes once it returns high.
- R11: Writes to offset 0x10 have no effect, and reads of any offset other than the six mapped ones (including misaligned ones) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NPINS | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | NPINS | Read data, 0 when bus_rd is low |
| pin_in | input | NPINS | Pin input levels |
| pin_out | output | NPINS | Pin output levels |
| pin_oe | output | NPINS | Pin output enables |
| dig_en | input | NPINS | Per-pin digital-enable mask |
| port_en | input | 1 | Input capture enable |

## Verification
The bench builds the block with its defaults: 32 pins and an 8-bit byte address. With a full 32-bit word, random set, clear and toggle masks reach every bit position, including the top bit. The 8-bit address also lets the bench reach unmapped word offsets above the map and misaligned byte addresses. A half-width digital-enable mask splits the port into a live half and a forced-zero half, so masked and unmasked capture are checked in the same read.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Byte offsets of the register map
  localparam int OFF_DATA = 'h00;
  localparam int OFF_SET  = 'h04;
  localparam int OFF_CLR  = 'h08;
  localparam int OFF_TOG  = 'h0C;
  localparam int OFF_IN   = 'h10;
  localparam int OFF_DIR  = 'h14;

  typedef enum logic [2:0] {
    SEL_DATA,
    SEL_SET,
    SEL_CLR,
    SEL_TOG,
    SEL_IN,
    SEL_DIR,
    SEL_NONE
  } pio_sel_e;

endpackage

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_in_capture.sv
module pio_in_capture #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] sync_in,
  output logic [WIDTH-1:0] cap_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (enable) cap_q <= sync_in & mask;
  end
endmodule

// File: rtl/pio_out_bank.sv
module pio_out_bank
  import pio_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  pio_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);
  logic [WIDTH-1:0] data_nx;
  logic [WIDTH-1:0] dir_nx;

  always_comb begin
    data_nx = data_q;
    dir_nx  = dir_q;
    if (wr) begin
      unique case (sel)
        SEL_DATA: data_nx = wdata;
        SEL_SET:  data_nx = data_q | wdata;
        SEL_CLR:  data_nx = data_q & ~wdata;
        SEL_TOG:  data_nx = data_q ^ wdata;
        SEL_DIR:  dir_nx  = wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_nx;
      dir_q  <= dir_nx;
    end
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  dig_en,
  input  logic              port_en
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_TOG  = ADDR_W'(OFF_TOG);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFF_IN);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);

  pio_sel_e         sel;
  logic [NPINS-1:0] data_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] sync_q;
  logic [NPINS-1:0] in_q;

  always_comb begin
    case (bus_addr)
      A_DATA:  sel = SEL_DATA;
      A_SET:   sel = SEL_SET;
      A_CLR:   sel = SEL_CLR;
      A_TOG:   sel = SEL_TOG;
      A_IN:    sel = SEL_IN;
      A_DIR:   sel = SEL_DIR;
      default: sel = SEL_NONE;
    endcase
  end

  pio_out_bank #(.WIDTH(NPINS)) i_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_wr),
    .sel    (sel),
    .wdata  (bus_wdata),
    .data_q (data_q),
    .dir_q  (dir_q)
  );

  pio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (sync_q)
  );

  pio_in_capture #(.WIDTH(NPINS)) i_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (port_en),
    .mask    (dig_en),
    .sync_in (sync_q),
    .cap_q   (in_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_DATA: bus_rdata = data_q;
        SEL_IN:   bus_rdata = in_q;
        SEL_DIR:  bus_rdata = dir_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = data_q & dir_q;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
  import pio_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  dig_en,
  input logic              port_en,
  input logic [NPINS-1:0]  data_q,
  input logic [NPINS-1:0]  in_q
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_TOG = ADDR_W'(OFF_TOG);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFF_DIR);

  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=> data_q == ($past(data_q) | $past(bus_wdata))); // R3

  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=> data_q == ($past(data_q) & ~$past(bus_wdata))); // R4

  AST_TOG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TOG) |=> data_q == ($past(data_q) ^ $past(bus_wdata))); // R5

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == A_SET || bus_addr == A_CLR || bus_addr == A_TOG)) |-> bus_rdata == '0); // R6

  AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> pin_oe == $past(bus_wdata)); // R7

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R7

  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |=> (in_q & ~$past(dig_en)) == '0); // R9

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> $stable(in_q)); // R10
endmodule

bind pio_port pio_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .dig_en    (dig_en),
  .port_en   (port_en),
  .data_q    (data_q),
  .in_q      (in_q)
);

// File: tb/test_pio_port.sv
`timescale 1ns/1ps
module test_pio_port;
  localparam int NPINS  = 32;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [NPINS-1:0]  bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic [NPINS-1:0]  bus_rdata;
  logic [NPINS-1:0]  pin_in = '0;
  logic [NPINS-1:0]  pin_out;
  logic [NPINS-1:0]  pin_oe;
  logic [NPINS-1:0]  dig_en = '1;
  logic              port_en = 1'b1;

  int total = 0;
  int bad   = 0;

  logic [NPINS-1:0] m_data = '0;
  logic [NPINS-1:0] m_dir  = '0;

  always #2 clk = ~clk;

  pio_port #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_pio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .dig_en(dig_en), .port_en(port_en)
  );

  task automatic check(string req, logic [NPINS-1:0] act, logic [NPINS-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NPINS-1:0] apply_op(int op, logic [NPINS-1:0] cur, logic [NPINS-1:0] w);
    case (op)
      'h00:    return w;
      'h04:    return cur | w;
      'h08:    return cur & ~w;
      'h0C:    return cur ^ w;
      default: return cur;
    endcase
  endfunction

  task automatic bus_write(int addr, logic [NPINS-1:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(addr); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(int addr, output logic [NPINS-1:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(addr); bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NPINS-1:0] rd;
    logic [NPINS-1:0] pa;
    logic [NPINS-1:0] pb;
    void'($urandom(32'h1234_5678));

    wait_cycles(3);
    #1;
    // R1: reset state
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    @(negedge clk) rst_n = 1'b1;
    bus_read('h00, rd); check("R1 data", rd, '0);
    bus_read('h14, rd); check("R1 dir", rd, '0);
    bus_read('h10, rd); check("R1 input", rd, '0);

    // R2: direct write then read next cycle
    bus_write('h00, 32'hA5A5_0F0F); m_data = 32'hA5A5_0F0F;
    bus_read('h00, rd); check("R2 data readback", rd, m_data);

    // R3/R4/R5 directed corner cases
    bus_write('h04, 32'h8000_0001); m_data = apply_op('h04, m_data, 32'h8000_0001);
    bus_read('h00, rd); check("R3 set edge bits", rd, m_data);
    bus_write('h08, 32'hFFFF_FFFF); m_data = '0;
    bus_read('h00, rd); check("R4 clear all", rd, m_data);
    bus_write('h0C, 32'hFFFF_FFFF); m_data = '1;
    bus_read('h00, rd); check("R5 toggle all", rd, m_data);
    bus_write('h04, '0);
    bus_read('h00, rd); check("R3 set zero mask no change", rd, m_data);

    // R6: write-only registers read 0
    bus_read('h04, rd); check("R6 set reads 0", rd, '0);
    bus_read('h08, rd); check("R6 clear reads 0", rd, '0);
    bus_read('h0C, rd); check("R6 toggle reads 0", rd, '0);

    // R7: direction gates output
    bus_write('h14, 32'h0000_FFFF); m_dir = 32'h0000_FFFF;
    #1;
    check("R7 pin_oe", pin_oe, m_dir);
    check("R7 pin_out", pin_out, m_data & m_dir);
    bus_read('h14, rd); check("R7 dir readback", rd, m_dir);

    // Random operations: R2..R5, R7
    for (int i = 0; i < 300; i++) begin
      int sel;
      int op;
      logic [NPINS-1:0] w;
      sel = int'($urandom_range(0, 4));
      w = $urandom();
      op = (sel == 4) ? 'h14 : sel * 4;
      bus_write(op, w);
      if (op == 'h14) m_dir = w;
      else m_data = apply_op(op, m_data, w);
      #1;
      if (sel == 1) check("R3 random set", pin_out, m_data & m_dir);
      else if (sel == 2) check("R4 random clear", pin_out, m_data & m_dir);
      else if (sel == 3) check("R5 random toggle", pin_out, m_data & m_dir);
      else check("R7 random pin_out", pin_out, m_data & m_dir);
      check("R7 random pin_oe", pin_oe, m_dir);
      bus_read('h00, rd); check("R2 random data", rd, m_data);
    end

    // R8: input capture latency
    pa = 32'hDEAD_BEEF;
    @(negedge clk) pin_in = pa;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = ADDR_W'('h10); bus_rd = 1'b1; #1;
    check("R8 not visible after two edges", bus_rdata, '0);
    @(posedge clk); @(negedge clk); #1;
    check("R8 visible after three edges", bus_rdata, pa);
    bus_rd = 1'b0;

    for (int i = 0; i < 20; i++) begin
      pb = $urandom();
      @(negedge clk) pin_in = pb;
      wait_cycles(4);
      bus_read('h10, rd); check("R8 random input", rd, pb);
    end

    // R9: digital-enable mask
    @(negedge clk) dig_en = 32'h0000_FFFF; pin_in = '1;
    wait_cycles(4);
    bus_read('h10, rd); check("R9 masked bits zero", rd, 32'h0000_FFFF);

    // R10: freeze while disabled
    @(negedge clk) dig_en = '1; pin_in = 32'h1234_5678;
    wait_cycles(4);
    @(negedge clk) port_en = 1'b0; pin_in = 32'h8765_4321;
    wait_cycles(6);
    bus_read('h10, rd); check("R10 frozen", rd, 32'h1234_5678);
    @(negedge clk) port_en = 1'b1;
    wait_cycles(2);
    bus_read('h10, rd); check("R10 resumed", rd, 32'h8765_4321);

    // R11: input register ignores writes, unmapped reads zero
    bus_write('h10, 32'hFFFF_FFFF);
    bus_read('h10, rd); check("R11 input write ignored", rd, 32'h8765_4321);
    bus_read('h00, rd); check("R11 data unaffected", rd, m_data);
    bus_read('h18, rd); check("R11 unmapped 0x18", rd, '0);
    bus_read('h02, rd); check("R11 misaligned 0x02", rd, '0);
    bus_read('hFC, rd); check("R11 unmapped 0xFC", rd, '0);
    bus_write('h18, 32'hFFFF_FFFF);
    bus_read('h00, rd); check("R11 unmapped write no effect", rd, m_data);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule